// File: doc/BRIEF.md
# Synchronous SRAM Core with Selectable Read and Turn-off Latency

This block is a behavioural synchronous static RAM with a small word array. Every command is registered on the rising clock edge: a chip-enable line, an address, write data, a per-byte strobe pair, a byte-write enable and a global-write line. The data path has a separate read-data output and a valid flag, both gated at once by an output-enable input that bypasses the clock.

Two mode inputs set the timing at run time. The read path can be flow-through, where data comes straight from the array in the cycle after the address is captured. It can also be pipelined, where the data goes through an output register and arrives one cycle later. The turn-off of the outputs after a deselect can be one stage shorter than the read path (single-cycle deselect) or as deep as it (dual-cycle deselect). With both mode inputs at zero, the block runs pipelined with single-cycle deselect. Writes go into the array on the edge that captures them, so a read captured on the next edge sees the new word.

Top module: `sync_sram_core`

## Requirements
- R1: After reset, with the chip disabled, `rdata_vld` is 0 and `rdata` is all zero.
- R2: With `ft_sel`=1 (flow-through), a read captured on edge k drives its word on `rdata` with `rdata_vld`=1 from edge k until edge k+1.
- R3: With `ft_sel`=0 (pipelined), a read captured on edge k drives the word the array held at edge k, from edge k+1 until edge k+2. A write to that word on edge k+1 does not change it.
- R4: In pipelined mode with `dcd_sel`=0 (single-cycle deselect), a cycle with `cs_en`=0 captured on edge k turns the outputs off from edge k. This includes the data of a read captured on edge k-1.
- R5: In pipelined mode with `dcd_sel`=1 (dual-cycle deselect), a read captured on edge k stays driven from edge k+1 until edge k+2 even when edge k+1 captures a deselect. The outputs go off after the next edge.
- R6: A write with `bw_en`=1 and `gw_en`=0 updates byte i of the word only when `byte_stb[i]`=1. Byte i is bits [9i+8:9i]. A cycle with both `bw_en` and `gw_en` at 0 is a read and changes nothing, whatever the strobes are.
- R7: `gw_en`=1 writes every byte of the addressed word, whatever `bw_en` and `byte_stb` are.
- R8: `oe` acts without the clock: while `oe`=0, `rdata_vld` is 0 and `rdata` is zero. Raising `oe` again at once restores the driven value.
- R9: A read captured on the edge after a write to the same address returns the newly written word.
- R10: Write cycles and deselected cycles never drive the outputs in their own output stage. In flow-through mode that stage starts at the capture edge; in pipelined mode it starts one edge later.
- R11: With `cs_en`=0, no write happens, even with `gw_en` or `bw_en` asserted.
- R12: With `ft_sel`=0 and `dcd_sel`=0, the block behaves as pipelined with single-cycle deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| ft_sel | input | 1 | 1 = flow-through reads, 0 = pipelined reads |
| dcd_sel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| cs_en | input | 1 | Chip enable, active high |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTE_W*N_BYTES | Write data |
| byte_stb | input | N_BYTES | Per-byte write strobes, used with bw_en |
| bw_en | input | 1 | Byte-write enable |
| gw_en | input | 1 | Global write, all bytes |
| oe | input | 1 | Output enable, acts without the clock |
| rdata | output | BYTE_W*N_BYTES | Read data, zero when not driven |
| rdata_vld | output | 1 | High while read data is driven |

## Verification
The bench uses the default build: a 16-word array of two 9-bit bytes. At that size, every address can be filled with a global write and read back in each of the four mode combinations. Every address also takes a byte-write with a different strobe pattern, so all strobe combinations land on real words. Short sequences of read then deselect, write then read, and suppressed writes cover the turn-off and forwarding corners in every mode. Mid-cycle toggles of the output enable check its unclocked gating.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/sram_cmd_capture.sv
module sram_cmd_capture
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int N_BYTES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_BYTES-1:0] byte_stb,
  input  logic               bw_en,
  input  logic               gw_en,
  output logic               wr_en,
  output logic [N_BYTES-1:0] wr_mask,
  output cmd_kind_e          kind_q,
  output logic [ADDR_W-1:0]  addr_q
);
  cmd_kind_e         kind_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_ce;

  // write mask decode, one lane per byte
  for (genvar b = 0; b < N_BYTES; b++) begin : g_mask
    assign wr_mask[b] = cs_en & (gw_en | (bw_en & byte_stb[b]));
  end
  assign wr_en = |wr_mask;

  always_comb begin
    if (!cs_en)               kind_d = CMD_IDLE;
    else if (gw_en || bw_en)  kind_d = CMD_WRITE;
    else                      kind_d = CMD_READ;
    addr_ce = cs_en;
    addr_d  = addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= CMD_IDLE;
    else        kind_q <= kind_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ce) addr_q <= addr_d;
  end

  // R11: a deselected cycle is captured as idle
  p_desel_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en |=> (kind_q == CMD_IDLE));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W  = 4,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [N_BYTES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [BYTE_W*N_BYTES-1:0] wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [BYTE_W*N_BYTES-1:0] rd_data
);
  localparam int WORD_W = BYTE_W * N_BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b])
        mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
    end

    // R6: an unstrobed byte keeps its old content across a write
    p_keep_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_mask[b]) |=>
        (mem[$past(wr_addr)][b*BYTE_W +: BYTE_W] ===
         $past(mem[wr_addr][b*BYTE_W +: BYTE_W])));
  end

  assign rd_data = mem[rd_addr];

  // R7: a full-mask write leaves the whole word equal to the written data
  p_full_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_mask)) |=> (mem[$past(wr_addr)] === $past(wr_data)));
endmodule

// File: rtl/sram_out_path.sv
module sram_out_path
  import sram_pkg::*;
#(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ft_sel,
  input  logic              dcd_sel,
  input  logic              oe,
  input  cmd_kind_e         kind_q,
  input  logic [WORD_W-1:0] arr_data,
  output logic [WORD_W-1:0] dout,
  output logic              dout_vld
);
  logic              rd_q2, rd_d2;
  logic [WORD_W-1:0] dreg_q, dreg_d;
  logic              dreg_ce;
  logic              drv_ft, drv_pl, drive;
  logic [WORD_W-1:0] sel_data;

  always_comb begin
    rd_d2   = (kind_q == CMD_READ);
    dreg_ce = (kind_q == CMD_READ);
    dreg_d  = arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q2 <= 1'b0;
    else        rd_q2 <= rd_d2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dreg_q <= '0;
    else if (dreg_ce) dreg_q <= dreg_d;
  end

  always_comb begin
    drv_ft   = (kind_q == CMD_READ);
    // single-cycle deselect cuts the registered stage as soon as idle is captured
    drv_pl   = rd_q2 && (dcd_sel || (kind_q != CMD_IDLE));
    drive    = ft_sel ? drv_ft : drv_pl;
    sel_data = ft_sel ? arr_data : dreg_q;
    dout_vld = oe && drive;
    dout     = dout_vld ? sel_data : '0;
  end

  // R3: the output register holds what the array showed at the read's capture
  p_pipe_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == CMD_READ) |=> (dreg_q === $past(arr_data)));

  // R4: single-cycle deselect, an idle capture silences the pipelined output
  p_scd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_sel && !dcd_sel && kind_q == CMD_IDLE) |-> !dout_vld);

  // R5: dual-cycle deselect keeps a read's data driven one edge later
  p_dcd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_sel && dcd_sel && kind_q == CMD_READ) |=>
      ((dout_vld || !oe || ft_sel || !dcd_sel)));

  // R8: output enable low forces an undriven, zero output
  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dout_vld && dout == '0));
endmodule

// File: rtl/sync_sram_core.sv
module sync_sram_core
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2,
  localparam int WORD_W = BYTE_W * N_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ft_sel,
  input  logic               dcd_sel,
  input  logic               cs_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [N_BYTES-1:0] byte_stb,
  input  logic               bw_en,
  input  logic               gw_en,
  input  logic               oe,
  output logic [WORD_W-1:0]  rdata,
  output logic               rdata_vld
);
  logic [1:0]         rst_sync;
  logic               srst_n;
  logic               wr_en;
  logic [N_BYTES-1:0] wr_mask;
  cmd_kind_e          kind_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  arr_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  sram_cmd_capture #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES)) u_cap (
    .clk(clk), .rst_n(srst_n), .cs_en(cs_en), .addr(addr),
    .byte_stb(byte_stb), .bw_en(bw_en), .gw_en(gw_en),
    .wr_en(wr_en), .wr_mask(wr_mask), .kind_q(kind_q), .addr_q(addr_q)
  );

  sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_arr (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_addr(addr), .wr_data(wdata), .rd_addr(addr_q), .rd_data(arr_data)
  );

  sram_out_path #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(srst_n), .ft_sel(ft_sel), .dcd_sel(dcd_sel), .oe(oe),
    .kind_q(kind_q), .arr_data(arr_data), .dout(rdata), .dout_vld(rdata_vld)
  );

  // R2: flow-through read captured with output enabled is driven after its edge
  p_ft_read_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (ft_sel && cs_en && !gw_en && !bw_en) |=> (rdata_vld || !oe || !ft_sel));

  // R10: a captured write never drives in flow-through mode
  p_write_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (ft_sel && cs_en && (gw_en || bw_en)) |=> (!rdata_vld || !ft_sel));
endmodule

// File: tb/sync_sram_core_test.sv
module sync_sram_core_test;
  localparam int AW = 4;
  localparam int WW = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ft_sel = 1'b0, dcd_sel = 1'b0;
  logic          cs_en = 1'b0, bw_en = 1'b0, gw_en = 1'b0, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wdata = '0;
  logic [1:0]    byte_stb = '0;
  logic [WW-1:0] rdata;
  logic          rdata_vld;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [WW-1:0] ref_mem [DEPTH];
  logic          cur_rd, prev_rd, cur_en;
  logic [WW-1:0] cur_val, prev_val;
  logic          exp_drv;
  logic [WW-1:0] exp_dat;

  always #10 clk = ~clk;

  sync_sram_core #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ft_sel(ft_sel), .dcd_sel(dcd_sel),
    .cs_en(cs_en), .addr(addr), .wdata(wdata), .byte_stb(byte_stb),
    .bw_en(bw_en), .gw_en(gw_en), .oe(oe), .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic check(input string tag, input logic ev, input logic [WW-1:0] ed);
    checks++;
    if (rdata_vld !== ev || rdata !== ed) begin
      failures++;
      $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h", tag, rdata_vld, rdata, ev, ed);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic [AW-1:0] a,
                      input logic g, input logic b, input logic [1:0] s, input logic [WW-1:0] d);
    cs_en = c; addr = a; gw_en = g; bw_en = b; byte_stb = s; wdata = d;
    @(posedge clk);
    prev_rd = cur_rd; prev_val = cur_val;
    if (c && (g || b))
      for (int i = 0; i < 2; i++)
        if (g || s[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
    cur_rd = c && !g && !b;
    cur_en = c;
    cur_val = cur_rd ? ref_mem[a] : '0;
    #5;
    if (ft_sel) begin exp_drv = cur_rd; exp_dat = cur_val; end
    else begin exp_drv = prev_rd && (dcd_sel || cur_en); exp_dat = prev_val; end
    check(tag, oe && exp_drv, (oe && exp_drv) ? exp_dat : '0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 2'b00, '0);
  endtask

  task automatic do_reset();
    cs_en = 1'b0; gw_en = 1'b0; bw_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
    cur_rd = 1'b0; prev_rd = 1'b0; cur_en = 1'b0; cur_val = '0; prev_val = '0;
    check("R1", 1'b0, '0);
    repeat (3) idle("R1");
  endtask

  function automatic logic [WW-1:0] pat(input int a, input int m, input int k);
    return WW'((a * 4663 + m * 911 + k * 52711 + 77) % (1 << WW));
  endfunction

  initial begin
    string rtag;
    for (int m = 0; m < 4; m++) begin
      ft_sel = m[0]; dcd_sel = m[1];
      do_reset();
      rtag = (m == 0) ? "R12" : (ft_sel ? "R2" : "R3");
      // global writes with strobes and byte-write mixed in
      for (int a = 0; a < DEPTH; a++)
        step("R7", 1'b1, AW'(a), 1'b1, a[0], 2'(a), pat(a, m, 0));
      for (int a = 0; a < DEPTH; a++) step(rtag, 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
      idle(rtag); idle("R10");
      // byte writes: every strobe pattern, plus strobes without enable (a read)
      for (int a = 0; a < DEPTH; a++)
        step("R6", 1'b1, AW'(a), 1'b0, 1'b1, 2'(a), pat(a, m, 1));
      for (int a = 0; a < 4; a++)
        step("R6", 1'b1, AW'(a), 1'b0, 1'b0, 2'b11, pat(a, m, 2));
      for (int a = 0; a < DEPTH; a++) step("R6", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
      idle("R10"); idle("R10");
      // read then deselect
      for (int a = 0; a < 4; a++) begin
        step(rtag, 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
        idle(dcd_sel ? "R5" : "R4");
        idle(dcd_sel ? "R5" : "R4");
      end
      // read followed by write to same address, then read after write
      for (int a = 4; a < 8; a++) begin
        step("R3", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
        step("R10", 1'b1, AW'(a), 1'b1, 1'b0, 2'b00, pat(a, m, 3));
        step("R9", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
        idle("R9");
      end
      // deselected write attempts must not land
      for (int a = 8; a < 12; a++) begin
        step("R11", 1'b0, AW'(a), 1'b1, 1'b1, 2'b11, pat(a, m, 4));
        step("R11", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
        idle("R11"); idle("R11");
      end
      // output enable: held low, then toggled mid-cycle
      oe = 1'b0;
      for (int a = 12; a < 16; a++) step("R8", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
      oe = 1'b1;
      for (int a = 12; a < 16; a++) begin
        step("R8", 1'b1, AW'(a), 1'b0, 1'b0, 2'b00, '0);
        oe = 1'b0; #1;
        check("R8", 1'b0, '0);
        oe = 1'b1; #1;
        check("R8", exp_drv, exp_drv ? exp_dat : '0);
      end
      idle("R10"); idle("R10");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule